// File: doc/BRIEF.md
# Trailing Bit Manipulation Unit

This execution unit takes one 64-bit operand per accepted transfer and returns one registered result. The operation is one of nine trailing-bit transforms or an immediate-controlled bit-field extract. Each trailing-bit transform combines the operand, its complement, and its increment or decrement. The result finds, fills, isolates or masks the lowest set bit or the lowest clear bit. A width select chooses 32-bit or 64-bit operation. A zero indicator travels with every result.

Operands enter through a valid/ready stream and results leave through a second valid/ready stream. The unit holds one result register. A new operand is accepted when that register is empty, or when its content is being taken in the same cycle (`in_ready = !out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the result and zero flag hold steady and no new operand is taken. The source drives `in_valid` high and keeps its payload stable until `in_ready` is seen. `out_ready` may change freely from cycle to cycle.

Top module: `tbm_exec_unit`

## Requirements
- R1: While synchronous reset `rst` is high, and in the first cycle after it falls, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` equals `!out_valid || out_ready`. An operand accepted on a clock edge appears as `out_valid` with its result after that same edge. While `out_valid && !out_ready`, `out_result` and `out_zero` do not change.
- R3: Lowest-set-bit codes. Op 0 gives src | (src-1). Op 1 gives ~src | (src-1). Op 2 gives ~src & (src-1).
- R4: Lowest-clear-bit codes. Op 3 gives src & (src+1). Op 4 gives src | ~(src+1). Op 5 gives ~src & (src+1). Op 6 gives src ^ (src+1). Op 7 gives src | (src+1). Op 8 gives ~src | (src+1).
- R5: Increment and decrement wrap modulo 2^width. A zero operand minus one is all ones. An all-ones operand plus one is zero.
- R6: With `in_narrow` = 1, only bits 31:0 of the operand take part in the operation, and result bits 63:32 are 0.
- R7: Op 9 extracts a field. The start bit is `in_ctrl[7:0]` and the length is `in_ctrl[15:8]`. Result bit i equals operand bit (start+i) for i < length, and is 0 otherwise.
- R8: In the extract, operand bits at or beyond the operand width (32 or 64) read as 0. A length of 0 gives a zero result.
- R9: `out_zero` is 1 exactly when `out_result` is 0.
- R10: Op codes 10 to 15 give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand transfer offered |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_op | input | 4 | Operation code |
| in_narrow | input | 1 | 1 selects 32-bit operation |
| in_src | input | 64 | Source operand |
| in_ctrl | input | 16 | Extract control: start in 7:0, length in 15:8 |
| out_valid | output | 1 | Result held and offered |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Registered result |
| out_zero | output | 1 | Result is zero |

## Verification
Acceptance of a new operand and drain of the held result can happen in the same cycle: `out_ready` is high while `in_valid` is offered against a full register. Random toggling of both `in_valid` and `out_ready` provokes this case often. A bench-side queue pairs each accepted operand with exactly one drained result, so a lost, duplicated or early result shows up as a miscompare. Stalled cycles are judged by comparing the held output with its value in the cycle before.

// File: rtl/tbm_pkg.sv
`timescale 1ns/1ps
package tbm_pkg;
  localparam int XLEN   = 64;
  localparam int CTRL_W = 16;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_FILL_SET = 4'd0,
    OP_HOLE_SET = 4'd1,
    OP_TZ_MASK  = 4'd2,
    OP_CLR_RUN  = 4'd3,
    OP_HOLE_CLR = 4'd4,
    OP_PICK_CLR = 4'd5,
    OP_MASK_CLR = 4'd6,
    OP_SET_CLR  = 4'd7,
    OP_INV_ONES = 4'd8,
    OP_EXTRACT  = 4'd9
  } op_e;
endpackage

// File: rtl/tbm_trail_logic.sv
`timescale 1ns/1ps
module tbm_trail_logic
  import tbm_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [OP_W-1:0] op,
  input  logic            narrow,
  input  logic [W-1:0]    src,
  output logic [W-1:0]    res
);
  localparam int HALF = W / 2;

  logic [W-1:0] opnd, inc, dec, raw, keep;

  assign keep = narrow ? {{(W-HALF){1'b0}}, {HALF{1'b1}}} : {W{1'b1}};
  assign opnd = src & keep;
  // Low half of +1/-1 is correct modulo 2^HALF; upper half is masked below.
  assign inc  = opnd + {{(W-1){1'b0}}, 1'b1};
  assign dec  = opnd - {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (op)
      OP_FILL_SET: raw = opnd | dec;
      OP_HOLE_SET: raw = ~opnd | dec;
      OP_TZ_MASK:  raw = ~opnd & dec;
      OP_CLR_RUN:  raw = opnd & inc;
      OP_HOLE_CLR: raw = opnd | ~inc;
      OP_PICK_CLR: raw = ~opnd & inc;
      OP_MASK_CLR: raw = opnd ^ inc;
      OP_SET_CLR:  raw = opnd | inc;
      OP_INV_ONES: raw = ~opnd | inc;
      default:     raw = '0;
    endcase
  end

  assign res = raw & keep;
endmodule

// File: rtl/tbm_field_extract.sv
`timescale 1ns/1ps
module tbm_field_extract
  import tbm_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int CW = CTRL_W
) (
  input  logic          narrow,
  input  logic [W-1:0]  src,
  input  logic [CW-1:0] ctrl,
  output logic [W-1:0]  res
);
  localparam int FW   = CW / 2;
  localparam int HALF = W / 2;

  logic [FW-1:0] start, len;
  logic [W-1:0]  opnd, shifted, lenmask;

  assign start = ctrl[FW-1:0];
  assign len   = ctrl[CW-1:FW];
  assign opnd  = narrow ? {{(W-HALF){1'b0}}, src[HALF-1:0]} : src;
  assign shifted = opnd >> start;

  for (genvar i = 0; i < W; i++) begin : g_len
    assign lenmask[i] = (i < int'(len));
  end

  assign res = shifted & lenmask;
endmodule

// File: rtl/tbm_exec_unit.sv
`timescale 1ns/1ps
module tbm_exec_unit
  import tbm_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int CW = CTRL_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OP_W-1:0] in_op,
  input  logic            in_narrow,
  input  logic [W-1:0]    in_src,
  input  logic [CW-1:0]   in_ctrl,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W-1:0]    out_result,
  output logic            out_zero
);
  localparam int HALF = W / 2;
  localparam int FW   = CW / 2;

  logic [W-1:0] trail_res, ext_res, next_res;
  logic         take;

  tbm_trail_logic #(.W(W)) u_trail (
    .op(in_op), .narrow(in_narrow), .src(in_src), .res(trail_res)
  );

  tbm_field_extract #(.W(W), .CW(CW)) u_ext (
    .narrow(in_narrow), .src(in_src), .ctrl(in_ctrl), .res(ext_res)
  );

  assign next_res = (in_op == OP_EXTRACT) ? ext_res : trail_res;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_zero   <= 1'b1;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) begin
        out_result <= next_res;
        out_zero   <= (next_res == '0);
      end
    end
  end

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_zero)));

  assert_accept_shows_R2: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

  assert_narrow_upper_R6: assert property (@(posedge clk) disable iff (rst)
    (take && in_narrow) |=> (out_result[W-1:HALF] == '0));

  assert_single_clear_bit_R4: assert property (@(posedge clk) disable iff (rst)
    (take && in_op == OP_PICK_CLR) |=> ($countones(out_result) <= 1));

  assert_zero_len_R8: assert property (@(posedge clk) disable iff (rst)
    (take && in_op == OP_EXTRACT && in_ctrl[CW-1:FW] == '0) |=> (out_result == '0 && out_zero));

  assert_spare_codes_R10: assert property (@(posedge clk) disable iff (rst)
    (take && in_op > OP_EXTRACT) |=> out_zero);
endmodule

// File: tb/tbm_exec_unit_test.sv
`timescale 1ns/1ps
module tbm_exec_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, in_narrow, out_valid, out_ready, out_zero;
  logic [3:0]  in_op;
  logic [63:0] in_src, out_result;
  logic [15:0] in_ctrl;

  int checks = 0;
  int fails  = 0;

  typedef struct { logic [63:0] val; string tag; } exp_t;
  exp_t pend[$];

  logic        prev_stall = 1'b0;
  logic [63:0] prev_res;
  logic        prev_zero;

  always #2 clk = ~clk;

  tbm_exec_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_narrow(in_narrow), .in_src(in_src), .in_ctrl(in_ctrl),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_zero(out_zero)
  );

  function automatic logic [63:0] model(input logic [3:0] op, input logic nar,
                                        input logic [63:0] s, input logic [15:0] c);
    logic [63:0] r;
    logic [31:0] a, p, m;
    int w;
    if (op == 4'd9) begin
      r = '0;
      w = nar ? 32 : 64;
      for (int i = 0; i < 64; i++)
        if (i < int'(c[15:8]) && int'(c[7:0]) + i < w) r[i] = s[int'(c[7:0]) + i];
      return r;
    end
    if (nar) begin
      a = s[31:0]; p = a + 32'd1; m = a - 32'd1;
      case (op)
        4'd0: r = {32'd0, a | m};
        4'd1: r = {32'd0, ~a | m};
        4'd2: r = {32'd0, ~a & m};
        4'd3: r = {32'd0, a & p};
        4'd4: r = {32'd0, a | ~p};
        4'd5: r = {32'd0, ~a & p};
        4'd6: r = {32'd0, a ^ p};
        4'd7: r = {32'd0, a | p};
        4'd8: r = {32'd0, ~a | p};
        default: r = '0;
      endcase
    end else begin
      case (op)
        4'd0: r = s | (s - 64'd1);
        4'd1: r = ~s | (s - 64'd1);
        4'd2: r = ~s & (s - 64'd1);
        4'd3: r = s & (s + 64'd1);
        4'd4: r = s | ~(s + 64'd1);
        4'd5: r = ~s & (s + 64'd1);
        4'd6: r = s ^ (s + 64'd1);
        4'd7: r = s | (s + 64'd1);
        4'd8: r = ~s | (s + 64'd1);
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  function automatic string op_tag(input logic [3:0] op);
    if (op <= 4'd2) return "R3";
    if (op <= 4'd8) return "R4";
    if (op == 4'd9) return "R7";
    return "R10";
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, settle, observe both handshakes before posedge.
  task automatic step(input logic iv, input logic [3:0] op, input logic nar,
                      input logic [63:0] s, input logic [15:0] c, input logic ordy,
                      input string tag, output bit accepted);
    exp_t e;
    @(negedge clk);
    if (prev_stall) begin
      check(out_valid && out_result == prev_res && out_zero == prev_zero,
            "R2 hold", out_result, prev_res);
    end
    in_valid = iv; in_op = op; in_narrow = nar; in_src = s; in_ctrl = c; out_ready = ordy;
    #1;
    check(in_ready == (!out_valid || out_ready), "R2 ready", 64'(in_ready), 64'(!out_valid || out_ready));
    if (out_valid && out_ready) begin
      if (pend.size() == 0) begin
        check(1'b0, "R2 spurious", out_result, 64'd0);
      end else begin
        e = pend.pop_front();
        check(out_result == e.val, e.tag, out_result, e.val);
        check(out_zero == (e.val == 64'd0), "R9", 64'(out_zero), 64'(e.val == 64'd0));
      end
    end
    accepted = iv && in_ready;
    if (accepted) begin
      e.val = model(op, nar, s, c);
      e.tag = (tag == "") ? op_tag(op) : tag;
      pend.push_back(e);
    end
    prev_stall = out_valid && !out_ready;
    prev_res = out_result;
    prev_zero = out_zero;
  endtask

  task automatic apply(input logic [3:0] op, input logic nar, input logic [63:0] s,
                       input logic [15:0] c, input string tag);
    bit acc;
    acc = 1'b0;
    while (!acc) step(1'b1, op, nar, s, c, 1'b1, tag, acc);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    bit acc;
    int unsigned seed;
    logic [63:0] rs;
    seed = 32'd20240611;
    void'($urandom(seed));
    rst = 1'b1; in_valid = 0; in_op = 0; in_narrow = 0; in_src = 0; in_ctrl = 0; out_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid && in_ready, "R1", 64'(out_valid), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && in_ready, "R1", 64'(out_valid), 64'd0);

    // Directed corner cases
    apply(4'd0, 0, 64'h0040201008040200, 16'h0, "R3");
    apply(4'd1, 0, 64'h0040201008040200, 16'h0, "R3");
    apply(4'd2, 0, 64'h0040201008040200, 16'h0, "R3");
    apply(4'd6, 0, 64'h80C0E0F0F8FCFEFF, 16'h0, "R4");
    apply(4'd5, 0, 64'h80C0E0F0F8FCFEFF, 16'h0, "R4");
    apply(4'd8, 0, 64'h80C0E0F0F8FCFEFF, 16'h0, "R4");
    apply(4'd0, 0, 64'h0, 16'h0, "R5");
    apply(4'd7, 0, 64'hFFFFFFFFFFFFFFFF, 16'h0, "R5");
    apply(4'd5, 0, 64'hFFFFFFFFFFFFFFFF, 16'h0, "R5");
    apply(4'd0, 1, 64'hFFFFFFFF00000000, 16'h0, "R6");
    apply(4'd7, 1, 64'h12345678FFFFFFFF, 16'h0, "R6");
    apply(4'd9, 0, 64'hFEDCBA9876543210, 16'h0C08, "R7");
    apply(4'd9, 1, 64'hFFFFFFFFFFFFFFFF, 16'h401C, "R8");
    apply(4'd9, 0, 64'hFFFFFFFFFFFFFFFF, 16'h003F, "R8");
    apply(4'd9, 0, 64'hFFFFFFFFFFFFFFFF, 16'hFF50, "R8");
    apply(4'd12, 0, 64'hFFFFFFFFFFFFFFFF, 16'h0, "R10");
    apply(4'd15, 1, 64'h0, 16'h0, "R10");

    // Random traffic with random back-pressure
    for (int n = 0; n < 4000; n++) begin
      rs = {$urandom(), $urandom()};
      if ($urandom_range(0, 7) == 0) rs = 64'hFFFFFFFFFFFFFFFF;
      if ($urandom_range(0, 7) == 0) rs = 64'h0;
      step($urandom_range(0, 3) != 0, 4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
           rs, 16'($urandom()), 1'($urandom_range(0, 2) != 0), "", acc);
    end
    for (int n = 0; n < 4; n++) step(1'b0, 4'd0, 1'b0, 64'd0, 16'd0, 1'b1, "", acc);
    check(pend.size() == 0, "R2 drain", 64'(pend.size()), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule